// File: doc/BRIEF.md
# Logarithmic-Depth Prefix Adder

This block adds two unsigned or two's-complement operands of `WIDTH` bits (16 by default) together with a carry-in. It returns the `WIDTH`-bit sum and the carry-out. It is purely combinational. Every bit first produces a propagate flag (the XOR of the two operand bits) and a generate flag (their AND). A prefix network then merges these flags into group flags that reach down to bit 0. Each carry equals the group generate ORed with the group propagate ANDed with the carry-in. Each sum bit is the bit's propagate XORed with the carry that enters it.

The depth of the carry network grows with the logarithm of the width instead of linearly. The parameter `TOPO` selects the network shape. The Brent-Kung option uses an up-sweep followed by a down-sweep, with few merge cells. The Han-Carlson option runs a dense tree over the odd bit positions and then adds one closing level that fills in the even positions. Both shapes must produce bit-identical results. `WIDTH` must be a power of two, at least 4.

Top module: `fast_prefix_adder`

## Requirements
- R1: `sum` equals the low `WIDTH` bits of `opnd_a + opnd_b + carry_in`, taken as unsigned integers.
- R2: `carry_out` equals bit `WIDTH` (the overflow bit of the unsigned addition) of `opnd_a + opnd_b + carry_in`.
- R3: When both operands are equal, no bit propagates. Then `sum` equals `{opnd_a[WIDTH-2:0], carry_in}` and `carry_out` equals `opnd_a[WIDTH-1]`.
- R4: When the operands have no set bit in common and `carry_in` is 0, no carry arises anywhere. Then `sum` equals `opnd_a | opnd_b` and `carry_out` is 0.
- R5: When `opnd_b` is the bitwise inverse of `opnd_a`, every bit propagates. Then every bit of `sum` equals the inverse of `carry_in`, and `carry_out` equals `carry_in`.
- R6: The Brent-Kung build (`TOPO = TOPO_BK`) and the Han-Carlson build (`TOPO = TOPO_HC`) give the same `sum` and `carry_out` for every input.
- R7: Corner sums are exact. All-ones plus one with carry-in 0 gives `sum` 0 and `carry_out` 1. Zero plus zero with carry-in 1 gives `sum` 1 and `carry_out` 0. All-ones plus all-ones with carry-in 1 gives `sum` all-ones and `carry_out` 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First addend |
| opnd_b | input | WIDTH | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| carry_out | output | 1 | Carry out of the most significant bit |

## Verification
The bench builds the block twice at the default width of 16. One copy uses `TOPO_BK` and the other uses `TOPO_HC`, and both copies receive the same operands. This lets each network be checked against an integer reference. It also lets the two networks be compared against each other, so a merge cell that is wired wrongly in only one topology stands out. The 16-bit width makes the bench reach every level of both trees, including the down-sweep and the even-position fix-up. It also lets the all-propagate and all-generate patterns drive a carry through all sixteen positions.

// File: rtl/adder_pkg.sv
`timescale 1ns/1ps
package adder_pkg;

  typedef enum logic {
    TOPO_BK = 1'b0,
    TOPO_HC = 1'b1
  } topo_e;

  typedef struct packed {
    logic p;
    logic g;
  } pg_t;

  // Merge an upper span with the adjacent lower span.
  function automatic pg_t pg_merge(input logic hi_p, input logic hi_g,
                                   input logic lo_p, input logic lo_g);
    pg_t r;
    r.p = hi_p & lo_p;
    r.g = hi_g | (hi_p & lo_g);
    return r;
  endfunction

  // Brent-Kung: levels 0..lg-1 are the up-sweep, the rest are the down-sweep.
  function automatic int bk_dist(input int s, input int lg);
    return (s < lg) ? (1 << s) : (1 << (2 * lg - 2 - s));
  endfunction

  function automatic bit bk_act(input int s, input int i, input int lg);
    int d;
    d = bk_dist(s, lg);
    if (s < lg) return ((i + 1) % (2 * d)) == 0;
    return (((i + 1) % (2 * d)) == d) && (i >= 2 * d);
  endfunction

  // Han-Carlson: level 0 pairs, levels 1..lg-1 form a dense tree on odd bits,
  // level lg fills in the even bits.
  function automatic int hc_dist(input int s, input int lg);
    return (s == 0 || s == lg) ? 1 : (1 << s);
  endfunction

  function automatic bit hc_act(input int s, input int i, input int lg);
    if (s == 0) return (i % 2) == 1;
    if (s == lg) return ((i % 2) == 0) && (i >= 2);
    return ((i % 2) == 1) && (i >= (1 << s) + 1);
  endfunction

  // Carry out of each position, given group flags reaching down to bit 0.
  function automatic logic [63:0] carries(input logic [63:0] gp, input logic [63:0] gg,
                                          input logic cin);
    return gg | (gp & {64{cin}});
  endfunction

endpackage

// File: rtl/adder_pg_gen.sv
`timescale 1ns/1ps
module adder_pg_gen #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] p,
  output logic [WIDTH-1:0] g
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign p[i] = a[i] ^ b[i];
    assign g[i] = a[i] & b[i];
  end
endmodule

// File: rtl/adder_prefix_bk.sv
`timescale 1ns/1ps
module adder_prefix_bk
  import adder_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] p_in,
  input  logic [WIDTH-1:0] g_in,
  output logic [WIDTH-1:0] p_out,
  output logic [WIDTH-1:0] g_out
);
  localparam int LG  = $clog2(WIDTH);
  localparam int NST = 2 * LG - 1;

  logic [WIDTH-1:0] cur_p, cur_g, nxt_p, nxt_g;
  pg_t m;

  always_comb begin
    cur_p = p_in;
    cur_g = g_in;
    nxt_p = p_in;
    nxt_g = g_in;
    m     = '0;
    for (int s = 0; s < NST; s++) begin
      nxt_p = cur_p;
      nxt_g = cur_g;
      for (int i = 0; i < WIDTH; i++) begin
        if (bk_act(s, i, LG)) begin
          m = pg_merge(cur_p[LG'(i)], cur_g[LG'(i)],
                       cur_p[LG'(i - bk_dist(s, LG))], cur_g[LG'(i - bk_dist(s, LG))]);
          nxt_p[LG'(i)] = m.p;
          nxt_g[LG'(i)] = m.g;
        end
      end
      cur_p = nxt_p;
      cur_g = nxt_g;
    end
  end

  assign p_out = cur_p;
  assign g_out = cur_g;
endmodule

// File: rtl/adder_prefix_hc.sv
`timescale 1ns/1ps
module adder_prefix_hc
  import adder_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] p_in,
  input  logic [WIDTH-1:0] g_in,
  output logic [WIDTH-1:0] p_out,
  output logic [WIDTH-1:0] g_out
);
  localparam int LG  = $clog2(WIDTH);
  localparam int NST = LG + 1;

  logic [WIDTH-1:0] cur_p, cur_g, nxt_p, nxt_g;
  pg_t m;

  always_comb begin
    cur_p = p_in;
    cur_g = g_in;
    nxt_p = p_in;
    nxt_g = g_in;
    m     = '0;
    for (int s = 0; s < NST; s++) begin
      nxt_p = cur_p;
      nxt_g = cur_g;
      for (int i = 0; i < WIDTH; i++) begin
        if (hc_act(s, i, LG)) begin
          m = pg_merge(cur_p[LG'(i)], cur_g[LG'(i)],
                       cur_p[LG'(i - hc_dist(s, LG))], cur_g[LG'(i - hc_dist(s, LG))]);
          nxt_p[LG'(i)] = m.p;
          nxt_g[LG'(i)] = m.g;
        end
      end
      cur_p = nxt_p;
      cur_g = nxt_g;
    end
  end

  assign p_out = cur_p;
  assign g_out = cur_g;
endmodule

// File: rtl/adder_sum_stage.sv
`timescale 1ns/1ps
module adder_sum_stage
  import adder_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] bit_p,
  input  logic [WIDTH-1:0] grp_p,
  input  logic [WIDTH-1:0] grp_g,
  input  logic             cin,
  output logic [WIDTH-1:0] carry,
  output logic [WIDTH-1:0] sum
);
  logic [63:0] c_full;

  assign c_full = carries(64'(grp_p), 64'(grp_g), cin);
  assign carry  = c_full[WIDTH-1:0];
  assign sum    = bit_p ^ {carry[WIDTH-2:0], cin};
endmodule

// File: rtl/fast_prefix_adder.sv
`timescale 1ns/1ps
module fast_prefix_adder
  import adder_pkg::*;
#(
  parameter int    WIDTH = 16,
  parameter topo_e TOPO  = TOPO_BK
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out
);
  // Named internal events for the checker.
  logic [WIDTH-1:0] bit_p, bit_g;
  logic [WIDTH-1:0] grp_p, grp_g;
  logic [WIDTH-1:0] carry_vec;

  adder_pg_gen #(.WIDTH(WIDTH)) u_pg (
    .a(opnd_a), .b(opnd_b), .p(bit_p), .g(bit_g)
  );

  if (TOPO == TOPO_BK) begin : g_bk
    adder_prefix_bk #(.WIDTH(WIDTH)) u_tree (
      .p_in(bit_p), .g_in(bit_g), .p_out(grp_p), .g_out(grp_g)
    );
  end else begin : g_hc
    adder_prefix_hc #(.WIDTH(WIDTH)) u_tree (
      .p_in(bit_p), .g_in(bit_g), .p_out(grp_p), .g_out(grp_g)
    );
  end

  adder_sum_stage #(.WIDTH(WIDTH)) u_sum (
    .bit_p(bit_p), .grp_p(grp_p), .grp_g(grp_g), .cin(carry_in),
    .carry(carry_vec), .sum(sum)
  );

  assign carry_out = carry_vec[WIDTH-1];
endmodule

// File: rtl/fast_prefix_adder_chk.sv
`timescale 1ns/1ps
module fast_prefix_adder_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic             carry_in,
  input logic [WIDTH-1:0] sum,
  input logic             carry_out,
  input logic [WIDTH-1:0] bit_p,
  input logic [WIDTH-1:0] bit_g,
  input logic [WIDTH-1:0] carry_vec
);
  always_comb begin
    // R1
    sum_value_chk: assert ({carry_out, sum} ==
                           ({1'b0, opnd_a} + {1'b0, opnd_b} + {{WIDTH{1'b0}}, carry_in}));
    // R2
    cout_top_chk: assert (carry_out == carry_vec[WIDTH-1]);
    // R3
    pg_exclusive_chk: assert ((bit_p & bit_g) == '0);
    // R4
    carry_kill_gen_chk: assert (((~bit_p) & (carry_vec ^ bit_g)) == '0);
    // R5
    all_prop_chk: assert (!(&bit_p) || (carry_vec == {WIDTH{carry_in}}));
  end
endmodule

bind fast_prefix_adder fast_prefix_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in),
  .sum(sum), .carry_out(carry_out),
  .bit_p(bit_p), .bit_g(bit_g), .carry_vec(carry_vec)
);

// File: tb/sim_fast_prefix_adder.sv
`timescale 1ns/1ps
module sim_fast_prefix_adder;
  import adder_pkg::*;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic         ci = 1'b0;
  logic [W-1:0] s_bk, s_hc;
  logic         co_bk, co_hc;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  fast_prefix_adder #(.WIDTH(W), .TOPO(TOPO_BK)) u0 (
    .opnd_a(a), .opnd_b(b), .carry_in(ci), .sum(s_bk), .carry_out(co_bk));
  fast_prefix_adder #(.WIDTH(W), .TOPO(TOPO_HC)) u1 (
    .opnd_a(a), .opnd_b(b), .carry_in(ci), .sum(s_hc), .carry_out(co_hc));

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Stimulus queue: {kind, cin, a, b}; kind 0 random, 1 equal, 2 disjoint, 3 inverse
  logic [34:0] vq[$];

  task automatic apply(input logic [34:0] v);
    int total, es, ec;
    logic [1:0] kind;
    @(posedge clk);
    #1;
    kind = v[34:33]; ci = v[32]; a = v[31:16]; b = v[15:0];
    @(negedge clk);
    total = int'(a) + int'(b) + int'(ci);
    es = total % 65536;
    ec = total / 65536;
    check("R1", "sum bk", int'(s_bk), es);
    check("R1", "sum hc", int'(s_hc), es);
    check("R2", "cout bk", int'(co_bk), ec);
    check("R2", "cout hc", int'(co_hc), ec);
    check("R6", "sum bk vs hc", int'(s_bk), int'(s_hc));
    check("R6", "cout bk vs hc", int'(co_bk), int'(co_hc));
    case (kind)
      2'd1: begin
        check("R3", "sum equal ops", int'(s_bk), int'({a[W-2:0], ci}));
        check("R3", "cout equal ops", int'(co_hc), int'(a[W-1]));
      end
      2'd2: begin
        check("R4", "sum disjoint", int'(s_hc), int'(a | b));
        check("R4", "cout disjoint", int'(co_bk), 0);
      end
      2'd3: begin
        check("R5", "sum all-prop", int'(s_bk), ci ? 0 : 65535);
        check("R5", "cout all-prop", int'(co_hc), int'(ci));
      end
      default: ;
    endcase
  endtask

  task automatic corner(input logic [W-1:0] x, input logic [W-1:0] y, input logic c,
                        input int es, input int ec);
    @(posedge clk);
    #1;
    a = x; b = y; ci = c;
    @(negedge clk);
    check("R7", "corner sum bk", int'(s_bk), es);
    check("R7", "corner sum hc", int'(s_hc), es);
    check("R7", "corner cout bk", int'(co_bk), ec);
    check("R7", "corner cout hc", int'(co_hc), ec);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state: zero operands give zero outputs (R1, R2)
    check("R1", "idle sum", int'(s_bk), 0);
    check("R2", "idle cout", int'(co_hc), 0);

    corner(16'hFFFF, 16'h0001, 1'b0, 0, 1);
    corner(16'h0000, 16'h0000, 1'b1, 1, 0);
    corner(16'hFFFF, 16'hFFFF, 1'b1, 65535, 1);
    corner(16'h8000, 16'h8000, 1'b0, 0, 1);

    for (int k = 0; k < 600; k++) begin
      logic [15:0] x, y, m;
      logic c;
      x = 16'($urandom); y = 16'($urandom); c = 1'($urandom); m = 16'($urandom);
      vq.push_back({2'd0, c, x, y});
      vq.push_back({2'd1, c, x, x});
      vq.push_back({2'd2, 1'b0, x & m, y & ~m});
      vq.push_back({2'd3, c, x, ~x});
    end
    while (vq.size() > 0) apply(vq.pop_front());

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule